// File: doc/BRIEF.md
# Display Memory Command and Address Controller

This block sits between a byte-level host link and the pixel memory of a 96-column by 68-row monochrome panel. Each incoming byte carries a flag that marks it as either a command or a display data byte. Commands move a page pointer and a column pointer, set the scroll origin, switch the display mode flags and request an identification read. A data byte is a vertical strip of eight pixels in one column of one page, and the block turns it into a single memory write.

The memory has nine pages. Pages 0 to 7 hold eight rows each, and page 8 holds only the last four rows. A set bit lights a pixel and a clear bit leaves it dark. The column pointer is loaded in two halves by separate commands. It advances after every data write and stops at the last column. The scan engine reads the start line register and the mode flags from this block. Power saver is not a command of its own: it is the state where the display is off and all points are forced on, reached in either order.

Top module: `lcdc_ram_ctrl`

## Requirements
- R1: After a synchronous reset, page, column and start line are 0. Display enable, all-points-on, power saver, the power control bits, the write strobe and the identification request are all 0.
- R2: A data byte (in_dc=1) arriving on pages 0 to 7 gives mem_we=1 on the next cycle. mem_addr is page*96+column and mem_wdata equals the byte unchanged, with bit value 1 meaning a lit pixel.
- R3: Every accepted data write moves the column up by one. A write at column 5Fh leaves the column at 5Fh, so the next write goes to 5Fh again.
- R4: Command 0xh (00h–0Fh) loads column bits 3:0 from x. Command 1xh (10h–17h) loads column bits 6:4 from x[2:0]. Each command leaves the other column bits as they were.
- R5: A data byte that arrives while the column is above 5Fh gives no write, and the column keeps its value.
- R6: Command B0h+n with n from 0 to 8 selects page n. Bytes B9h–BFh leave the page unchanged.
- R7: A data write on page 8 drives mem_wdata[7:4] to 0 and passes bits 3:0 through.
- R8: Command 40h+n (40h–7Fh) sets the start line to n, from 0 to 63.
- R9: AEh turns the display off and AFh turns it on. A4h turns all-points-on off and A5h turns it on.
- R10: power_save is 1 exactly when the display is off and all-points-on is set. It reaches that state whichever of the two commands comes last, and it leaves it as soon as either flag changes.
- R11: Commands 28h–2Fh load the three power control bits from byte bits 2:0, so 2Fh turns all three on.
- R12: Command DBh raises id_req for exactly one cycle.
- R13: No command byte ever produces a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_dc | input | 1 | 1 = display data byte, 0 = command byte |
| in_byte | input | 8 | Byte value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 10 | Memory word address, page*96+column |
| mem_wdata | output | 8 | Memory write data, one column of one page |
| disp_on | output | 1 | Display enabled |
| all_on | output | 1 | All pixels forced on |
| power_save | output | 1 | Display off while all points on |
| start_line | output | 6 | Memory line shown on the top display row |
| pwr_ctrl | output | 3 | Booster, regulator and follower enables |
| id_req | output | 1 | One-cycle request to return the identification byte |

## Verification
A corrupted column or page register shows up on the next data write, as a mem_addr that differs from page*96+column one cycle after that byte. A missed increment or a failed saturation is exposed by the second write in a run. A wrong mode flag or power saver term appears on the port one cycle after the command that should have set it. Because of this, the bench checks the outputs after every byte. A page or column that a command was supposed to leave alone is checked through the address of the following write.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef struct packed {
    logic       wr_data;
    logic       col_lo;
    logic       col_hi;
    logic       page;
    logic       line;
    logic       all_pts;
    logic       disp;
    logic       pwr;
    logic       id_rd;
    logic [7:0] arg;
  } lcdc_dec_t;

endpackage

// File: rtl/lcdc_cmd_decode.sv
module lcdc_cmd_decode
  import lcdc_pkg::*;
#(
  parameter int PAGES = 9
) (
  input  logic       in_valid,
  input  logic       in_dc,
  input  logic [7:0] in_byte,
  output lcdc_dec_t  dec
);

  localparam logic [3:0] PAGE_LIMIT = 4'(PAGES);

  always_comb begin
    dec     = '0;
    dec.arg = in_byte;
    if (in_valid) begin
      if (in_dc) begin
        dec.wr_data = 1'b1;
      end else begin
        dec.col_lo  = (in_byte[7:4] == 4'h0);
        dec.col_hi  = (in_byte[7:3] == 5'b00010);
        dec.pwr     = (in_byte[7:3] == 5'b00101);
        dec.line    = (in_byte[7:6] == 2'b01);
        dec.all_pts = (in_byte[7:1] == 7'b1010010);
        dec.disp    = (in_byte[7:1] == 7'b1010111);
        dec.page    = (in_byte[7:4] == 4'hB) && (in_byte[3:0] < PAGE_LIMIT);
        dec.id_rd   = (in_byte == 8'hDB);
      end
    end
  end

endmodule

// File: rtl/lcdc_addr_ctrl.sv
module lcdc_addr_ctrl
  import lcdc_pkg::*;
#(
  parameter int COLS           = 96,
  parameter int PAGES          = 9,
  parameter int LAST_PAGE_ROWS = 4,
  parameter int ADDR_W         = $clog2(PAGES * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  lcdc_dec_t         dec,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int COL_W = 7;
  localparam int PAGE_W = $clog2(PAGES);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);

  logic [COL_W-1:0]  col_q;
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        last_mask;
  logic              wr_ok;

  generate
    if (LAST_PAGE_ROWS < 8) begin : g_short_page
      assign last_mask = 8'((1 << LAST_PAGE_ROWS) - 1);
    end else begin : g_full_page
      assign last_mask = 8'hFF;
    end
  endgenerate

  assign wr_ok = dec.wr_data && (col_q <= LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q  <= '0;
      page_q <= '0;
    end else begin
      if (dec.col_lo) col_q[3:0] <= dec.arg[3:0];
      if (dec.col_hi) col_q[COL_W-1:4] <= dec.arg[COL_W-5:0];
      if (dec.page) page_q <= dec.arg[PAGE_W-1:0];
      if (wr_ok && (col_q < LAST_COL)) col_q <= col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_ok;
      if (wr_ok) begin
        mem_addr  <= ADDR_W'(page_q) * ADDR_W'(COLS) + ADDR_W'(col_q);
        mem_wdata <= (page_q == LAST_PAGE) ? (dec.arg & last_mask) : dec.arg;
      end
    end
  end

  assert_col_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (dec.wr_data && col_q < LAST_COL) |=> col_q == $past(col_q) + COL_W'(1));

  assert_col_hold_at_end_R3: assert property (@(posedge clk) disable iff (rst)
    (dec.wr_data && col_q == LAST_COL && !dec.col_lo && !dec.col_hi) |=> col_q == LAST_COL);

  assert_write_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(col_q) <= LAST_COL);

  assert_page_by_cmd_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_q) |-> $past(dec.page));

  assert_no_cmd_write_R13: assert property (@(posedge clk) disable iff (rst)
    !dec.wr_data |=> !mem_we);

  assert_short_page_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(page_q) == LAST_PAGE) |-> (mem_wdata & ~last_mask) == 8'h00);

endmodule

// File: rtl/lcdc_mode_regs.sv
module lcdc_mode_regs
  import lcdc_pkg::*;
#(
  parameter int LINE_W = 6,
  parameter int PWR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  lcdc_dec_t         dec,
  output logic              disp_on,
  output logic              all_on,
  output logic              power_save,
  output logic [LINE_W-1:0] start_line,
  output logic [PWR_W-1:0]  pwr_ctrl,
  output logic              id_req
);

  logic disp_nxt;
  logic all_nxt;

  always_comb begin
    disp_nxt = dec.disp    ? dec.arg[0] : disp_on;
    all_nxt  = dec.all_pts ? dec.arg[0] : all_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_on    <= 1'b0;
      all_on     <= 1'b0;
      power_save <= 1'b0;
      start_line <= '0;
      pwr_ctrl   <= '0;
      id_req     <= 1'b0;
    end else begin
      disp_on    <= disp_nxt;
      all_on     <= all_nxt;
      power_save <= !disp_nxt && all_nxt;
      id_req     <= dec.id_rd;
      if (dec.line) start_line <= dec.arg[LINE_W-1:0];
      if (dec.pwr) pwr_ctrl <= dec.arg[PWR_W-1:0];
    end
  end

  assert_saver_entry_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(power_save) |-> $past(dec.disp || dec.all_pts));

  assert_line_by_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(start_line) |-> $past(dec.line));

  assert_id_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    id_req |-> $past(dec.id_rd));

  assert_pwr_by_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(pwr_ctrl) |-> $past(dec.pwr));

endmodule

// File: rtl/lcdc_ram_ctrl.sv
module lcdc_ram_ctrl
  import lcdc_pkg::*;
#(
  parameter int COLS           = 96,
  parameter int PAGES          = 9,
  parameter int LAST_PAGE_ROWS = 4,
  parameter int LINE_W         = 6,
  parameter int PWR_W          = 3,
  parameter int ADDR_W         = $clog2(PAGES * COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_dc,
  input  logic [7:0]        in_byte,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              disp_on,
  output logic              all_on,
  output logic              power_save,
  output logic [LINE_W-1:0] start_line,
  output logic [PWR_W-1:0]  pwr_ctrl,
  output logic              id_req
);

  lcdc_dec_t dec;

  lcdc_cmd_decode #(
    .PAGES(PAGES)
  ) i_decode (
    .in_valid(in_valid),
    .in_dc   (in_dc),
    .in_byte (in_byte),
    .dec     (dec)
  );

  lcdc_addr_ctrl #(
    .COLS          (COLS),
    .PAGES         (PAGES),
    .LAST_PAGE_ROWS(LAST_PAGE_ROWS),
    .ADDR_W        (ADDR_W)
  ) i_addr (
    .clk      (clk),
    .rst      (rst),
    .dec      (dec),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata)
  );

  lcdc_mode_regs #(
    .LINE_W(LINE_W),
    .PWR_W (PWR_W)
  ) i_modes (
    .clk       (clk),
    .rst       (rst),
    .dec       (dec),
    .disp_on   (disp_on),
    .all_on    (all_on),
    .power_save(power_save),
    .start_line(start_line),
    .pwr_ctrl  (pwr_ctrl),
    .id_req    (id_req)
  );

endmodule

// File: tb/test_lcdc_ram_ctrl.sv
module test_lcdc_ram_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_dc = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       mem_we;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       disp_on;
  logic       all_on;
  logic       power_save;
  logic [5:0] start_line;
  logic [2:0] pwr_ctrl;
  logic       id_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcdc_ram_ctrl i_lcdc_ram_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .disp_on(disp_on), .all_on(all_on), .power_save(power_save),
    .start_line(start_line), .pwr_ctrl(pwr_ctrl), .id_req(id_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic dc, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_dc    = dc;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    send(1'b0, b);
    check("R13 no write on command", int'(mem_we), 0);
  endtask

  task automatic write_expect(input logic [7:0] b, input int addr, input int data, input string req);
    send(1'b1, b);
    check({req, " we"}, int'(mem_we), 1);
    check({req, " addr"}, int'(mem_addr), addr);
    check({req, " data"}, int'(mem_wdata), data);
  endtask

  task automatic t_reset_R1();
    check("R1 we", int'(mem_we), 0);
    check("R1 disp", int'(disp_on), 0);
    check("R1 all", int'(all_on), 0);
    check("R1 saver", int'(power_save), 0);
    check("R1 line", int'(start_line), 0);
    check("R1 pwr", int'(pwr_ctrl), 0);
    check("R1 id", int'(id_req), 0);
    write_expect(8'hA5, 0, 8'hA5, "R1 first write at page0 col0");
  endtask

  task automatic t_write_R2();
    write_expect(8'h3C, 1, 8'h3C, "R2");
    write_expect(8'h00, 2, 8'h00, "R2");
    write_expect(8'hFF, 3, 8'hFF, "R2");
    cmd(8'hB2); cmd(8'h11); cmd(8'h04);
    write_expect(8'h81, 2*96 + 8'h14, 8'h81, "R2 page2 col14");
  endtask

  task automatic t_saturate_R3();
    cmd(8'hB1); cmd(8'h15); cmd(8'h0E);
    write_expect(8'h11, 96 + 8'h5E, 8'h11, "R3 at 5E");
    write_expect(8'h22, 96 + 8'h5F, 8'h22, "R3 at 5F");
    write_expect(8'h33, 96 + 8'h5F, 8'h33, "R3 held at 5F");
  endtask

  task automatic t_nibbles_R4_R5();
    cmd(8'hB0); cmd(8'h17); cmd(8'h03);
    send(1'b1, 8'h77);
    check("R5 no write beyond 5F", int'(mem_we), 0);
    cmd(8'h10);
    write_expect(8'h44, 8'h03, 8'h44, "R4 R5 low nibble kept, col unchanged");
    cmd(8'h0A);
    write_expect(8'h45, 8'h0A, 8'h45, "R4 low nibble only");
    cmd(8'h12);
    write_expect(8'h46, 8'h2B, 8'h46, "R4 high bits only");
  endtask

  task automatic t_page_R6_R7();
    cmd(8'hB3); cmd(8'h10); cmd(8'h00);
    write_expect(8'h5A, 3*96, 8'h5A, "R6 page3");
    cmd(8'hBA); cmd(8'h00);
    write_expect(8'h5B, 3*96, 8'h5B, "R6 BA ignored");
    cmd(8'hB8); cmd(8'h10); cmd(8'h00);
    write_expect(8'hFF, 8*96, 8'h0F, "R7 page8 mask");
    write_expect(8'hA6, 8*96 + 1, 8'h06, "R7 page8 mask");
  endtask

  task automatic t_line_R8();
    cmd(8'h40); check("R8 line 0", int'(start_line), 0);
    cmd(8'h7F); check("R8 line 63", int'(start_line), 63);
    cmd(8'h55); check("R8 line 21", int'(start_line), 8'h15);
    send(1'b1, 8'h41); check("R8 data byte leaves line", int'(start_line), 8'h15);
  endtask

  task automatic t_modes_R9_R10();
    cmd(8'hAF); check("R9 on", int'(disp_on), 1); check("R10 saver off", int'(power_save), 0);
    cmd(8'hA5); check("R9 all on", int'(all_on), 1); check("R10 on+all no saver", int'(power_save), 0);
    cmd(8'hAE); check("R9 off", int'(disp_on), 0); check("R10 saver via off last", int'(power_save), 1);
    cmd(8'hA4); check("R9 all off", int'(all_on), 0); check("R10 saver exit", int'(power_save), 0);
    cmd(8'hA5); check("R10 saver via all last", int'(power_save), 1);
    cmd(8'hAF); check("R10 saver exit on", int'(power_save), 0);
    cmd(8'hA4);
  endtask

  task automatic t_pwr_id_R11_R12();
    cmd(8'h2F); check("R11 all on", int'(pwr_ctrl), 7);
    cmd(8'h2A); check("R11 pattern", int'(pwr_ctrl), 2);
    cmd(8'h28); check("R11 all off", int'(pwr_ctrl), 0);
    cmd(8'hDB); check("R12 pulse", int'(id_req), 1);
    @(negedge clk); check("R12 one cycle", int'(id_req), 0);
    send(1'b1, 8'hDB); check("R12 data DB no request", int'(id_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_R1();
    t_write_R2();
    t_saturate_R3();
    t_nibbles_R4_R5();
    t_page_R6_R7();
    t_line_R8();
    t_modes_R9_R10();
    t_pwr_id_R11_R12();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 line after reset", int'(start_line), 0);
    check("R1 saver after reset", int'(power_save), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule